// File: doc/BRIEF.md
# Write-Through No-Allocate Data Cache

This block sits between a processor's load/store port and a slow word-organised backing store. The backing store is an internal array of rows, each row several 32-bit words wide. A word is picked by a row number and a word-within-row index, both taken directly from fields of the word address. In front of it sits a small direct-mapped cache. Each line holds one word, a tag and a valid flag.

A load that finds its word in the cache completes after a short fixed stall. A load that misses waits the long backing-store stall, installs the word in its line and then returns it. Every store is written to the backing store and pays the long stall. A store updates the cached copy only when that address is already present; a store miss leaves every line untouched.

The requester offers an operation with `req_i` while `ready_o` is high. It then watches `busy_o` during the stall and collects the result in the single cycle in which `done_o` pulses.

Top module: `wt_cache`

## Requirements
- R1: After reset, `ready_o`=1, `busy_o`=0 and `done_o`=0, and every line is invalid, so the first load of any address is a miss. Reset does not alter the backing-store contents.
- R2: An operation is accepted on a rising clock edge where `req_i` and `ready_o` are both 1. From the next cycle `ready_o` is 0 until the `done_o` cycle.
- R3: `busy_o` is 1 for exactly the stall count of the operation, starting in the cycle after acceptance. `done_o` is 1 for exactly one cycle, immediately after the last busy cycle. In that cycle `ready_o`=1 and `busy_o`=0.
- R4: A load hit stalls HIT_STALL cycles (default 1) and returns the cached word on `rdata_o` in the `done_o` cycle.
- R5: A load miss stalls MISS_STALL cycles (default 10), returns the backing-store word, and installs it, so that an immediate reload of the same address hits.
- R6: Every store writes `wdata_i` to the backing store and stalls MISS_STALL cycles, whether it hits or misses.
- R7: A store that hits overwrites the cached word, so a following load of that address hits and returns the new value.
- R8: A store that misses allocates nothing and does not disturb the line at its index, so a following load of the stored address misses. A resident word at the same index still hits.
- R9: The line index is the low log2(LINES) bits of the word address (bits [2:0] by default) and the tag is the remaining upper bits. Two addresses with equal index and different tag evict each other.
- R10: In the word address, bits [ADDR_W-1:log2(ROW_WORDS)] select the row and the low log2(ROW_WORDS) bits select the word in that row. All RAM_ROWS*ROW_WORDS words are distinct storage.
- R11: `req_i` asserted while `ready_o` is 0 has no effect: a store offered during another operation's stall and withdrawn before `done_o` is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Operation request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | WORD_W (32) | Store data |
| ready_o | output | 1 | Idle, request can be accepted |
| busy_o | output | 1 | Operation in progress (stall) |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | WORD_W (32) | Load data, valid with `done_o` |

## Verification
The bench builds the block with its defaults: 8 lines, 16 rows of 4 words, a stall of 1 on a hit and 10 on a backing-store access. With only 8 lines and 64 words, addresses 5, 13 and 21 share one line. This puts eviction, a store miss onto a resident neighbour and a store hit within a few operations. The 64-word space is small enough to fill and read back completely, which exposes any row/word field mix-up. The clearly different stall counts make every hit or miss visible as a stall length at the ports.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } ctrl_state_e;
endpackage

// File: rtl/wt_row_ram.sv
module wt_row_ram #(
  parameter int WORD_W    = 32,
  parameter int ROW_WORDS = 4,
  parameter int RAM_ROWS  = 16,
  localparam int WSEL_W   = $clog2(ROW_WORDS),
  localparam int ROW_W    = $clog2(RAM_ROWS),
  localparam int ADDR_W   = ROW_W + WSEL_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [RAM_ROWS][ROW_WORDS];
  logic [ROW_W-1:0]  row;
  logic [WSEL_W-1:0] wsel;

  assign row  = addr_i[ADDR_W-1:WSEL_W];
  assign wsel = addr_i[WSEL_W-1:0];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[row][wsel] <= wdata_i;
  end

  assign rdata_o = mem_q[row][wsel];
endmodule

// File: rtl/wt_line_store.sv
module wt_line_store #(
  parameter int WORD_W  = 32,
  parameter int LINES   = 8,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] lk_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic              valid_q [LINES];
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [WORD_W-1:0] data_q  [LINES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;

  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign wr_idx = wr_addr_i[IDX_W-1:0];
  assign wr_tag = wr_addr_i[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) valid_q[i] <= 1'b0;
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data_i;
    end
  end

  assign hit_o     = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data_o = data_q[lk_idx];
endmodule

// File: rtl/wt_ctrl.sv
module wt_ctrl
  import wt_cache_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int ADDR_W     = 6,
  parameter int HIT_STALL  = 1,
  parameter int MISS_STALL = 10,
  localparam int CNT_W     = $clog2(MISS_STALL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              hit_i,
  input  logic [WORD_W-1:0] line_data_i,
  input  logic [WORD_W-1:0] ram_data_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              ram_we_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  output logic              line_we_o,
  output logic [WORD_W-1:0] line_wdata_o
);
  ctrl_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              we_q, hit_q, done_q;
  logic              accept, fin;

  assign accept = (state_q == ST_IDLE) && req_i;
  assign fin    = (state_q == ST_WAIT) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= fin;
      if (accept) begin
        state_q <= ST_WAIT;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
        hit_q   <= hit_i;
        // stores always pay the backing-store latency
        cnt_q   <= (we_i || !hit_i) ? CNT_W'(MISS_STALL - 1) : CNT_W'(HIT_STALL - 1);
      end else if (fin) begin
        state_q <= ST_IDLE;
        if (!we_q) rdata_q <= hit_q ? line_data_i : ram_data_i;
      end else if (state_q == ST_WAIT) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign busy_o       = (state_q == ST_WAIT);
  assign done_o       = done_q;
  assign rdata_o      = rdata_q;
  assign lk_addr_o    = (state_q == ST_IDLE) ? addr_i : addr_q;
  assign op_addr_o    = addr_q;
  assign ram_we_o     = fin && we_q;
  assign ram_wdata_o  = wdata_q;
  // fill on load miss, overwrite on store hit, nothing otherwise
  assign line_we_o    = fin && (we_q == hit_q);
  assign line_wdata_o = we_q ? wdata_q : ram_data_i;
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int WORD_W     = 32,
  parameter int ROW_WORDS  = 4,
  parameter int RAM_ROWS   = 16,
  parameter int LINES      = 8,
  parameter int HIT_STALL  = 1,
  parameter int MISS_STALL = 10,
  localparam int ADDR_W    = $clog2(ROW_WORDS) + $clog2(RAM_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rdata_o
);
  logic              hit, ram_we, line_we;
  logic [ADDR_W-1:0] lk_addr, op_addr;
  logic [WORD_W-1:0] line_data, ram_data, ram_wdata, line_wdata;

  wt_ctrl #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W),
    .HIT_STALL(HIT_STALL), .MISS_STALL(MISS_STALL)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .hit_i(hit), .line_data_i(line_data), .ram_data_i(ram_data),
    .ready_o, .busy_o, .done_o, .rdata_o,
    .lk_addr_o(lk_addr), .op_addr_o(op_addr),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata),
    .line_we_o(line_we), .line_wdata_o(line_wdata)
  );

  wt_line_store #(.WORD_W(WORD_W), .LINES(LINES), .ADDR_W(ADDR_W)) u_lines (
    .clk_i, .rst_ni,
    .lk_addr_i(lk_addr), .hit_o(hit), .lk_data_o(line_data),
    .wr_en_i(line_we), .wr_addr_i(op_addr), .wr_data_i(line_wdata)
  );

  wt_row_ram #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .RAM_ROWS(RAM_ROWS)) u_ram (
    .clk_i, .we_i(ram_we), .addr_i(op_addr), .wdata_i(ram_wdata), .rdata_o(ram_data)
  );
endmodule

// File: rtl/wt_cache_checker.sv
module wt_cache_checker #(
  parameter int HIT_STALL  = 1,
  parameter int MISS_STALL = 10,
  localparam int CNT_W     = $clog2(MISS_STALL + 2)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic ready_o,
  input logic busy_o,
  input logic done_o
);
  logic             acc, acc_we_q;
  logic [CNT_W-1:0] busy_cnt_q;

  assign acc = req_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt_q <= '0;
      acc_we_q   <= 1'b0;
    end else if (acc) begin
      busy_cnt_q <= '0;
      acc_we_q   <= we_i;
    end else if (busy_o) begin
      busy_cnt_q <= busy_cnt_q + 1'b1;
    end
  end

  assert_accept_stalls_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (busy_o && !ready_o));
  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && !busy_o));
  assert_no_overrun_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt_q < CNT_W'(MISS_STALL)));
  assert_store_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && acc_we_q) |-> (busy_cnt_q == CNT_W'(MISS_STALL)));
  assert_load_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !acc_we_q) |->
      (busy_cnt_q == CNT_W'(HIT_STALL) || busy_cnt_q == CNT_W'(MISS_STALL)));
endmodule

bind wt_cache wt_cache_checker #(.HIT_STALL(HIT_STALL), .MISS_STALL(MISS_STALL)) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .ready_o(ready_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/wt_cache_bench.sv
`timescale 1ns/1ps
module wt_cache_bench;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ready_o, busy_o, done_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  wt_cache u_wt_cache (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .ready_o, .busy_o, .done_o, .rdata_o
  );

  // {we, addr[7:0], wdata, exp_rdata, exp_stall[7:0]}
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'd5,  32'hA5A5_0005, 32'h0,           8'd10}, // R6 store miss
    {1'b1, 8'd13, 32'h1300_00D3, 32'h0,           8'd10}, // R6
    {1'b0, 8'd5,  32'h0,         32'hA5A5_0005,   8'd10}, // R8 R5 no allocate
    {1'b0, 8'd5,  32'h0,         32'hA5A5_0005,   8'd1 }, // R4 hit
    {1'b0, 8'd13, 32'h0,         32'h1300_00D3,   8'd10}, // R9 evicts 5
    {1'b0, 8'd5,  32'h0,         32'hA5A5_0005,   8'd10}, // R9 evicted
    {1'b1, 8'd5,  32'h5555_AAAA, 32'h0,           8'd10}, // R6 store hit
    {1'b0, 8'd5,  32'h0,         32'h5555_AAAA,   8'd1 }, // R7
    {1'b1, 8'd21, 32'h2100_0021, 32'h0,           8'd10}, // R6 miss same index
    {1'b0, 8'd5,  32'h0,         32'h5555_AAAA,   8'd1 }, // R8 neighbour kept
    {1'b0, 8'd21, 32'h0,         32'h2100_0021,   8'd10}, // R5
    {1'b1, 8'd63, 32'hFFFF_003F, 32'h0,           8'd10}, // R6
    {1'b0, 8'd63, 32'h0,         32'hFFFF_003F,   8'd10}, // R5
    {1'b0, 8'd63, 32'h0,         32'hFFFF_003F,   8'd1 }, // R4
    {1'b0, 8'd13, 32'h0,         32'h1300_00D3,   8'd10}  // R9
  };
  string vtag [NV] = '{"R6", "R6", "R8", "R4", "R9", "R9", "R6", "R7",
                       "R6", "R8", "R5", "R6", "R5", "R4", "R9"};

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // issue one operation, return stall length and load data
  task automatic run_op(input bit we, input logic [5:0] a, input logic [31:0] d,
                        output int stall, output logic [31:0] rd);
    @(negedge clk);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0;
    stall = 0;
    while (!done_o) begin
      if (busy_o) stall++;
      @(negedge clk);
    end
    rd = rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ready_o === 1'b1, "R1 ready", ready_o, 1);
    check(busy_o === 1'b0, "R1 busy", busy_o, 0);
    check(done_o === 1'b0, "R1 done", done_o, 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][80], 6'(VEC[i][79:72]), VEC[i][71:40], st, rd);
      check(st == int'(VEC[i][7:0]), {vtag[i], " stall"}, st, VEC[i][7:0]);
      if (!VEC[i][80]) check(rd === VEC[i][39:8], {vtag[i], " data"}, rd, VEC[i][39:8]);
      check(ready_o && !busy_o, "R3 idle at done", {ready_o, busy_o}, 2);
    end

    // R10: fill every word, read all back
    for (int a = 0; a < 64; a++) run_op(1'b1, 6'(a), 32'hC0DE_0000 | a, st, rd);
    for (int a = 0; a < 64; a++) begin
      run_op(1'b0, 6'(a), 32'h0, st, rd);
      check(rd === (32'hC0DE_0000 | a), "R10 word", rd, 32'hC0DE_0000 | a);
      check(st == 10, "R9 conflict miss", st, 10);
    end
    @(negedge clk);
    check(done_o === 1'b0, "R3 pulse width", done_o, 0);

    // R1: reset clears lines, keeps backing store
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(ready_o && !busy_o && !done_o, "R1 after reset", {ready_o, busy_o, done_o}, 4);
    rst_ni = 1'b1;
    run_op(1'b0, 6'd63, 32'h0, st, rd);
    check(st == 10, "R1 cold miss", st, 10);
    check(rd === 32'hC0DE_003F, "R1 store kept", rd, 32'hC0DE_003F);
    run_op(1'b0, 6'd63, 32'h0, st, rd);
    check(st == 1, "R5 refill hit", st, 1);

    // R11/R2: request during stall is ignored
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = 6'd7; wdata_i = 32'h0000_7777;
    @(negedge clk);
    we_i = 1'b1; addr_i = 6'd9; wdata_i = 32'hDEAD_BEEF;
    check(ready_o === 1'b0, "R2 not ready", ready_o, 0);
    repeat (4) @(negedge clk);
    req_i = 1'b0;
    while (!done_o) @(negedge clk);
    run_op(1'b0, 6'd9, 32'h0, st, rd);
    check(rd === 32'hC0DE_0009, "R11 ignored store", rd, 32'hC0DE_0009);
    run_op(1'b0, 6'd7, 32'h0, st, rd);
    check(rd === 32'h0000_7777, "R6 accepted store", rd, 32'h0000_7777);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule